// File: doc/BRIEF.md
# Cost-Based Memory Controller Selector

When a page fault needs a physical frame, this block picks the memory controller whose address slice should receive the page. Each controller reports three statistics: its average queuing delay, its row-buffer hit rate, and, for every core, the hop count from that core to the controller. The block scores each controller as `A*delay + B*hitrate + C*hops(core)` using three programmable weights. It returns the index with the lowest score. The hit-rate term is a penalty. A controller that already misses often in its row buffers loses little from one more page, so the penalty steers new pages toward it.

Each thread keeps a record of its five most recent cost-based choices and the timestamp of its latest fault. Suppose a thread faults again no more than a fixed window after its previous fault and its record is not empty. Then the block skips the scoring and returns the controller that appears most often in the record. Fault requests enter on a valid/ready stream. The answer leaves on a second valid/ready stream with one registered result slot. The block accepts a new request only when that slot is empty or is being drained in the same cycle. A consumer that holds `rsp_ready_i` low therefore stalls the request side. The weights and statistics are plain level inputs.

Top module: `mc_picker`

## Requirements
- R1: After reset `rsp_valid_o` is 0 and `req_ready_o` is 1. The weights start at A=10, B=20, C=100.
- R2: For a scored request, the controller cost is `A*delay[j] + B*hitrate[j] + C*hops[core][j]`, and the lowest cost wins. A higher hit rate raises the cost. The answer appears on `rsp_mc_o` with `rsp_valid_o`=1 in the cycle after the request is accepted. Field j of `load_i` and `rate_i` is bits `[j*W +: W]`. Hops for core c and controller j are field `c*NUM_MC+j` of `dist_i`.
- R3: When two or more controllers share the lowest cost, the lowest index wins.
- R4: A cycle with `cfg_wr_i`=1 loads all three weights. Requests accepted from the next cycle on use them. The cost arithmetic is wide enough that all-ones statistics and weights never wrap.
- R5: A thread whose record is empty is always scored, whatever its timestamp.
- R6: If the record is non-empty and `(ts - last_ts) mod 2^TS_W <= WINDOW` (default 5000), the result is the most frequent entry in the record, and the statistics have no effect. A difference of WINDOW+1 is scored.
- R7: When several entries share the highest count in the record, the lowest controller index among them is returned.
- R8: Every scored result enters the record as its newest entry. Once there are five entries, the oldest is dropped. Shortcut results are not recorded. The last timestamp is updated on every accepted fault.
- R9: While `rsp_valid_o`=1 and `rsp_ready_i`=0, the response holds its index and `req_ready_o` is 0. Once the response is taken with no new request, `rsp_valid_o` returns to 0.
- R10: A fault of one thread does not change the record or timestamp of any other thread.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_i | input | 1 | Load the three weights |
| cfg_alpha_i | input | WGT_W | Weight A for queuing delay |
| cfg_beta_i | input | WGT_W | Weight B for row-buffer hit rate |
| cfg_lambda_i | input | WGT_W | Weight C for hop distance |
| load_i | input | NUM_MC*LOAD_W | Per-controller average queuing delay |
| rate_i | input | NUM_MC*RATE_W | Per-controller row-buffer hit rate |
| dist_i | input | NUM_CORE*NUM_MC*DIST_W | Hop count for each core and controller pair |
| req_valid_i | input | 1 | Fault request valid |
| req_ready_o | output | 1 | Fault request accepted this cycle if valid |
| req_tid_i | input | TID_W | Faulting thread |
| req_core_i | input | CORE_W | Core the thread runs on |
| req_ts_i | input | TS_W | Fault timestamp in cycles |
| rsp_valid_o | output | 1 | Chosen controller valid |
| rsp_ready_i | input | 1 | Consumer takes the response |
| rsp_mc_o | output | IDX_W | Chosen controller index |

## Verification
Scored selection is swept over 160 generated statistic sets with varied core distances, under several weight settings. Each setting isolates one term, including a beta-only case that proves a high hit rate repels. Hand-built equal-cost patterns separate the lowest-index tie rule from any other order. A thread is then driven through a record sequence in which the newest entry, a dropped oldest entry and a tied vote would each give a different answer. Timestamp differences of exactly the window, one past it, and across counter wrap separate the shortcut path from the scoring path. A second thread interleaved with the first checks that threads stay independent.

// File: rtl/mcp_pkg.sv
package mcp_pkg;
  // index width that never collapses to zero bits
  function automatic int idx_w(input int n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/mcp_cost_argmin.sv
module mcp_cost_argmin import mcp_pkg::*; #(
  parameter int NUM_MC = 4,
  parameter int LOAD_W = 12,
  parameter int RATE_W = 8,
  parameter int DIST_W = 4,
  parameter int WGT_W  = 8,
  localparam int IDX_W  = idx_w(NUM_MC),
  localparam int COST_W = max3(LOAD_W, RATE_W, DIST_W) + WGT_W + 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_MC*LOAD_W-1:0]   load_i,
  input  logic [NUM_MC*RATE_W-1:0]   rate_i,
  input  logic [NUM_MC*DIST_W-1:0]   dist_i,
  input  logic [WGT_W-1:0]           w_load_i,
  input  logic [WGT_W-1:0]           w_rate_i,
  input  logic [WGT_W-1:0]           w_dist_i,
  output logic [IDX_W-1:0]           win_o
);
  logic [COST_W-1:0] cost [NUM_MC];

  for (genvar j = 0; j < NUM_MC; j++) begin : g_cost
    assign cost[j] = COST_W'(w_load_i) * COST_W'(load_i[j*LOAD_W +: LOAD_W])
                   + COST_W'(w_rate_i) * COST_W'(rate_i[j*RATE_W +: RATE_W])
                   + COST_W'(w_dist_i) * COST_W'(dist_i[j*DIST_W +: DIST_W]);
  end

  always_comb begin
    logic [COST_W-1:0] best;
    best  = cost[0];
    win_o = '0;
    for (int j = 1; j < NUM_MC; j++) begin
      if (cost[j] < best) begin   // strict: earlier index keeps ties
        best  = cost[j];
        win_o = IDX_W'(j);
      end
    end
  end

  for (genvar j = 0; j < NUM_MC; j++) begin : g_chk
    // R2: winner is not beaten by any controller
    p_min_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cost[win_o] <= cost[j]);
    // R3: equal cost never goes to a higher index
    p_tie_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cost[j] == cost[win_o]) |-> (win_o <= IDX_W'(j)));
  end
endmodule

// File: rtl/mcp_vote.sv
module mcp_vote import mcp_pkg::*; #(
  parameter int NUM_MC = 4,
  parameter int DEPTH  = 5,
  localparam int IDX_W = idx_w(NUM_MC),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [DEPTH*IDX_W-1:0]   hist_i,
  input  logic [CNT_W-1:0]         fill_i,
  output logic [IDX_W-1:0]         win_o
);
  logic [CNT_W-1:0] tally [NUM_MC];

  always_comb begin
    for (int m = 0; m < NUM_MC; m++) begin
      tally[m] = '0;
      for (int e = 0; e < DEPTH; e++) begin
        if ((e < int'(fill_i)) && (hist_i[e*IDX_W +: IDX_W] == IDX_W'(m)))
          tally[m] = tally[m] + CNT_W'(1);
      end
    end
  end

  always_comb begin
    logic [CNT_W-1:0] top;
    top   = tally[0];
    win_o = '0;
    for (int m = 1; m < NUM_MC; m++) begin
      if (tally[m] > top) begin
        top   = tally[m];
        win_o = IDX_W'(m);
      end
    end
  end

  for (genvar m = 0; m < NUM_MC; m++) begin : g_chk
    // R7: the vote winner has the top count, lowest index on a tie
    p_top_r7: assert property (@(posedge clk) disable iff (!rst_n)
      tally[win_o] >= tally[m]);
    p_tie_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (tally[m] == tally[win_o]) |-> (win_o <= IDX_W'(m)));
  end
endmodule

// File: rtl/mcp_hist_store.sv
module mcp_hist_store import mcp_pkg::*; #(
  parameter int NUM_THR = 16,
  parameter int DEPTH   = 5,
  parameter int NUM_MC  = 4,
  parameter int TS_W    = 32,
  localparam int IDX_W  = idx_w(NUM_MC),
  localparam int TID_W  = idx_w(NUM_THR),
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int HW     = DEPTH * IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TID_W-1:0]  tid_i,
  output logic [HW-1:0]     hist_o,
  output logic [CNT_W-1:0]  fill_o,
  output logic [TS_W-1:0]   ts_o,
  input  logic              upd_i,
  input  logic              push_i,
  input  logic [IDX_W-1:0]  push_val_i,
  input  logic [TS_W-1:0]   upd_ts_i
);
  logic [HW-1:0]    hist_q [NUM_THR];
  logic [CNT_W-1:0] fill_q [NUM_THR];
  logic [TS_W-1:0]  ts_q   [NUM_THR];

  assign hist_o = hist_q[tid_i];
  assign fill_o = fill_q[tid_i];
  assign ts_o   = ts_q[tid_i];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int t = 0; t < NUM_THR; t++) begin
        hist_q[t] <= '0;
        fill_q[t] <= '0;
        ts_q[t]   <= '0;
      end
    end else if (upd_i) begin
      for (int t = 0; t < NUM_THR; t++) begin
        if (tid_i == TID_W'(t)) begin
          ts_q[t] <= upd_ts_i;
          if (push_i) begin
            // newest in the low field, oldest falls off the top
            hist_q[t] <= {hist_q[t][HW-IDX_W-1:0], push_val_i};
            if (fill_q[t] != CNT_W'(DEPTH))
              fill_q[t] <= fill_q[t] + CNT_W'(1);
          end
        end
      end
    end
  end

  for (genvar t = 0; t < NUM_THR; t++) begin : g_chk
    // R8: a push lands as the newest entry
    p_push_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_i && push_i && tid_i == TID_W'(t)) |=>
        (hist_q[t][IDX_W-1:0] == $past(push_val_i)));
    // R8: a shortcut leaves the record untouched
    p_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_i && !push_i && tid_i == TID_W'(t)) |=>
        ($stable(hist_q[t]) && $stable(fill_q[t])));
    // R10: other threads' state does not move
    p_iso_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (tid_i != TID_W'(t)) |=> ($stable(hist_q[t]) && $stable(ts_q[t])));
  end
endmodule

// File: rtl/mc_picker.sv
module mc_picker import mcp_pkg::*; #(
  parameter int NUM_MC     = 4,
  parameter int NUM_CORE   = 16,
  parameter int NUM_THR    = 16,
  parameter int HIST_DEPTH = 5,
  parameter int WINDOW     = 5000,
  parameter int LOAD_W     = 12,
  parameter int RATE_W     = 8,
  parameter int DIST_W     = 4,
  parameter int WGT_W      = 8,
  parameter int TS_W       = 32,
  parameter int RST_ALPHA  = 10,
  parameter int RST_BETA   = 20,
  parameter int RST_LAMBDA = 100,
  localparam int IDX_W  = idx_w(NUM_MC),
  localparam int TID_W  = idx_w(NUM_THR),
  localparam int CORE_W = idx_w(NUM_CORE),
  localparam int CNT_W  = $clog2(HIST_DEPTH + 1),
  localparam int ROW_W  = NUM_MC * DIST_W
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             cfg_wr_i,
  input  logic [WGT_W-1:0]                 cfg_alpha_i,
  input  logic [WGT_W-1:0]                 cfg_beta_i,
  input  logic [WGT_W-1:0]                 cfg_lambda_i,
  input  logic [NUM_MC*LOAD_W-1:0]         load_i,
  input  logic [NUM_MC*RATE_W-1:0]         rate_i,
  input  logic [NUM_CORE*ROW_W-1:0]        dist_i,
  input  logic                             req_valid_i,
  output logic                             req_ready_o,
  input  logic [TID_W-1:0]                 req_tid_i,
  input  logic [CORE_W-1:0]                req_core_i,
  input  logic [TS_W-1:0]                  req_ts_i,
  output logic                             rsp_valid_o,
  input  logic                             rsp_ready_i,
  output logic [IDX_W-1:0]                 rsp_mc_o
);
  logic [WGT_W-1:0] w_a_q, w_b_q, w_c_q;
  logic [ROW_W-1:0] dist_row;
  logic [IDX_W-1:0] cost_win, vote_win, choice;
  logic [HIST_DEPTH*IDX_W-1:0] thr_hist;
  logic [CNT_W-1:0] thr_fill;
  logic [TS_W-1:0]  thr_ts, gap;
  logic             fire, fast;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w_a_q <= WGT_W'(RST_ALPHA);
      w_b_q <= WGT_W'(RST_BETA);
      w_c_q <= WGT_W'(RST_LAMBDA);
    end else if (cfg_wr_i) begin
      w_a_q <= cfg_alpha_i;
      w_b_q <= cfg_beta_i;
      w_c_q <= cfg_lambda_i;
    end
  end

  assign dist_row = dist_i[int'(req_core_i)*ROW_W +: ROW_W];

  mcp_cost_argmin #(
    .NUM_MC(NUM_MC), .LOAD_W(LOAD_W), .RATE_W(RATE_W),
    .DIST_W(DIST_W), .WGT_W(WGT_W)
  ) u_cost (
    .clk(clk), .rst_n(rst_n),
    .load_i(load_i), .rate_i(rate_i), .dist_i(dist_row),
    .w_load_i(w_a_q), .w_rate_i(w_b_q), .w_dist_i(w_c_q),
    .win_o(cost_win)
  );

  mcp_hist_store #(
    .NUM_THR(NUM_THR), .DEPTH(HIST_DEPTH), .NUM_MC(NUM_MC), .TS_W(TS_W)
  ) u_hist (
    .clk(clk), .rst_n(rst_n), .tid_i(req_tid_i),
    .hist_o(thr_hist), .fill_o(thr_fill), .ts_o(thr_ts),
    .upd_i(fire), .push_i(!fast), .push_val_i(cost_win), .upd_ts_i(req_ts_i)
  );

  mcp_vote #(.NUM_MC(NUM_MC), .DEPTH(HIST_DEPTH)) u_vote (
    .clk(clk), .rst_n(rst_n),
    .hist_i(thr_hist), .fill_i(thr_fill), .win_o(vote_win)
  );

  assign gap    = req_ts_i - thr_ts;   // modular difference
  assign fast   = (thr_fill != '0) && (gap <= TS_W'(WINDOW));
  assign choice = fast ? vote_win : cost_win;

  assign req_ready_o = !rsp_valid_o || rsp_ready_i;
  assign fire        = req_valid_i && req_ready_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_o <= 1'b0;
      rsp_mc_o    <= '0;
    end else if (fire) begin
      rsp_valid_o <= 1'b1;
      rsp_mc_o    <= choice;
    end else if (rsp_ready_i) begin
      rsp_valid_o <= 1'b0;
    end
  end

  // R9: a stalled response holds
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_o && !rsp_ready_i) |=> (rsp_valid_o && $stable(rsp_mc_o)));
  // R9: no intake while the slot is stuck
  p_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_o && !rsp_ready_i) |-> !req_ready_o);
  // R2: an accepted request answers next cycle
  p_answer_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> rsp_valid_o);
  // R6: shortcut answers come from the vote
  p_fast_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && fast) |=> (rsp_mc_o == $past(vote_win)));
  // R5: an empty record is always scored
  p_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && thr_fill == '0) |=> (rsp_mc_o == $past(cost_win)));
endmodule

// File: tb/tb_mc_picker.sv
module tb_mc_picker;
  localparam int NM = 4, NC = 16, NT = 16, DEP = 5, WIN = 5000;
  localparam int LW = 12, RW = 8, DW = 4, WW = 8, TW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr = 1'b0;
  logic [WW-1:0] cfg_a = '0, cfg_b = '0, cfg_c = '0;
  logic [NM*LW-1:0] load_v;
  logic [NM*RW-1:0] rate_v;
  logic [NC*NM*DW-1:0] dist_v;
  logic req_valid = 1'b0, req_ready;
  logic [3:0] req_tid = '0, req_core = '0;
  logic [TW-1:0] req_ts = '0;
  logic rsp_valid, rsp_ready = 1'b1;
  logic [1:0] rsp_mc;

  always #4 clk = ~clk;   // 125 MHz

  mc_picker dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr_i(cfg_wr), .cfg_alpha_i(cfg_a), .cfg_beta_i(cfg_b), .cfg_lambda_i(cfg_c),
    .load_i(load_v), .rate_i(rate_v), .dist_i(dist_v),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_tid_i(req_tid), .req_core_i(req_core), .req_ts_i(req_ts),
    .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready), .rsp_mc_o(rsp_mc)
  );

  int ld [NM];
  int rt [NM];
  int ds [NC][NM];
  int wa = 10, wb = 20, wl = 100;
  int mh [NT][DEP];
  int mf [NT];
  logic [TW-1:0] mts [NT];
  int checks = 0, errors = 0;
  bit finished = 0;

  always_comb for (int j = 0; j < NM; j++) load_v[j*LW +: LW] = LW'(ld[j]);
  always_comb for (int j = 0; j < NM; j++) rate_v[j*RW +: RW] = RW'(rt[j]);
  always_comb
    for (int c = 0; c < NC; c++)
      for (int j = 0; j < NM; j++) dist_v[(c*NM+j)*DW +: DW] = DW'(ds[c][j]);

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int exp_cost(int core);
    longint best = 0;
    int bi = 0;
    for (int j = 0; j < NM; j++) begin
      longint c;
      c = longint'(wa) * ld[j] + longint'(wb) * rt[j] + longint'(wl) * ds[core][j];
      if (j == 0 || c < best) begin best = c; bi = j; end
    end
    return bi;
  endfunction

  function automatic int exp_vote(int tid);
    int cnt [NM];
    int bi = 0;
    for (int m = 0; m < NM; m++) cnt[m] = 0;
    for (int e = 0; e < mf[tid]; e++) cnt[mh[tid][e]]++;
    for (int m = 1; m < NM; m++) if (cnt[m] > cnt[bi]) bi = m;
    return bi;
  endfunction

  task automatic set_win(int w);
    for (int j = 0; j < NM; j++) begin
      ld[j] = (j == w) ? 0 : 1000;
      rt[j] = 0;
      for (int c = 0; c < NC; c++) ds[c][j] = 0;
    end
  endtask

  task automatic wcfg(int a, int b, int c);
    wa = a; wb = b; wl = c;
    @(negedge clk);
    cfg_a = WW'(a); cfg_b = WW'(b); cfg_c = WW'(c); cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic req(int tid, int core, logic [TW-1:0] ts, string tag);
    logic [TW-1:0] d;
    bit fast;
    int e;
    d = ts - mts[tid];
    fast = (mf[tid] > 0) && (d <= TW'(WIN));
    e = fast ? exp_vote(tid) : exp_cost(core);
    if (!fast) begin
      for (int k = DEP - 1; k > 0; k--) mh[tid][k] = mh[tid][k-1];
      mh[tid][0] = e;
      if (mf[tid] < DEP) mf[tid]++;
    end
    mts[tid] = ts;
    @(negedge clk);
    req_tid = 4'(tid); req_core = 4'(core); req_ts = ts; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " valid"}, int'(rsp_valid), 1);
    chk({tag, " index"}, int'(rsp_mc), e);
  endtask

  initial begin
    for (int t = 0; t < NT; t++) begin mf[t] = 0; mts[t] = '0; end
    for (int j = 0; j < NM; j++) begin
      ld[j] = 0; rt[j] = 0;
      for (int c = 0; c < NC; c++) ds[c][j] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rsp_valid after reset", int'(rsp_valid), 0);
    chk("R1 req_ready after reset", int'(req_ready), 1);

    // R1 default weights decide: costs 500,500,400,200
    ld[0] = 50; ld[1] = 40; ld[2] = 10; ld[3] = 10;
    rt[2] = 10;
    ds[0][1] = 1; ds[0][2] = 1; ds[0][3] = 1;
    req(0, 0, 32'd100, "R1 reset weights");

    // record sequence on thread 3
    set_win(1); req(3, 5, 32'd10,    "R5 empty record scored");
    set_win(2); req(3, 5, 32'd20,    "R6 close fault reuses record");
    req(3, 5, 32'd5020,              "R6 gap equal to window");
    req(3, 5, 32'd10021,             "R6 gap window+1 scored");
    set_win(0); req(3, 5, 32'd10030, "R7 vote tie to lowest");
    set_win(2); req(3, 5, 32'd16100, "R8 push");
    set_win(3); req(3, 5, 32'd22200, "R8 push");
    req(3, 5, 32'd28300,             "R8 push");
    set_win(0); req(3, 5, 32'd28310, "R8 shortcut not recorded");
    set_win(1); req(3, 5, 32'd34400, "R8 push past depth");
    set_win(0); req(3, 5, 32'd34410, "R8 oldest dropped");

    // R10: another thread close in time is still scored
    set_win(3); req(4, 2, 32'd34420, "R10 other thread scored");
    set_win(0); req(3, 5, 32'd34430, "R10 thread record kept");

    // R6 timestamp wrap
    set_win(1); req(6, 1, 32'hFFFF_FFF0, "R6 before wrap");
    set_win(0); req(6, 1, 32'h0000_0010, "R6 gap across wrap");

    // R3 ties
    for (int j = 0; j < NM; j++) begin ld[j] = 7; rt[j] = 3; end
    for (int c = 0; c < NC; c++) for (int j = 0; j < NM; j++) ds[c][j] = 2;
    req(8, 4, 32'd100, "R3 all equal");
    ld[0] = 5; ld[1] = 3; ld[2] = 9; ld[3] = 3;
    req(9, 4, 32'd100, "R3 tie between 1 and 3");

    // R4 weights
    wcfg(0, 0, 1);
    set_win(0); ld[2] = 4000; ld[0] = 100;
    ds[2][0] = 9; ds[2][1] = 7; ds[2][2] = 1; ds[2][3] = 8;
    req(10, 2, 32'd100, "R4 distance only");
    wcfg(0, 1, 0);
    rt[0] = 200; rt[1] = 50; rt[2] = 100; rt[3] = 60;
    req(12, 2, 32'd100, "R2 high hit rate repels");
    wcfg(255, 255, 255);
    for (int j = 0; j < NM; j++) begin ld[j] = 4095; rt[j] = 255; end
    for (int c = 0; c < NC; c++) for (int j = 0; j < NM; j++) ds[c][j] = 15;
    ld[3] = 4094;
    req(11, 7, 32'd100, "R4 no wrap at full scale");
    wcfg(10, 20, 100);

    // R9 back-pressure
    set_win(2);
    rsp_ready = 1'b0;
    req(13, 3, 32'd100, "R9 stalled response");
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R9 valid held", int'(rsp_valid), 1);
      chk("R9 index held", int'(rsp_mc), 2);
      chk("R9 intake blocked", int'(req_ready), 0);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    chk("R9 drained", int'(rsp_valid), 0);

    // R2 sweep with occasional close follow-ups
    for (int p = 0; p < 160; p++) begin
      logic [TW-1:0] base;
      base = TW'(2000000 + p * 6000);
      for (int j = 0; j < NM; j++) begin
        ld[j] = (p * 37 + j * 53 + (p / 7) * j * 11) % 4096;
        rt[j] = (p * 29 + j * 71) % 256;
        for (int c = 0; c < NC; c++) ds[c][j] = (c * 3 + j * 5 + p) % 16;
      end
      req(p % NT, (p * 5) % NC, base, "R2 sweep");
      if (p % 4 == 0) req(p % NT, (p * 5) % NC, base + 100, "R6 sweep follow-up");
    end

    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule